// File: doc/BRIEF.md
# Protected Configuration and Signature Access Controller

This block sits between a command source and the configuration state of a programmable device. It serves seven operations over a one-cycle command strobe: reading and writing words of a configuration array, loading a bank of logic registers with a forced state for test, reading and writing one byte of an eight-byte user signature, arming a one-way protection bit, and a full erase. Each accepted command produces exactly one response pulse one cycle later, either an acknowledge with data or an error.

The protection bit gates two operations only: reading the configuration array back and forcing the logic registers. Once armed, both are refused from the very next command onward. The signature stays open to reads and writes at all times, so a part can carry a name, revision or date even when its contents are protected. The protection bit can only be cleared by a full erase, which also wipes the configuration array. The nonvolatile cells are modelled as plain registers.

Top module: `sec_access_ctrl`

## Requirements
- R1: After synchronous reset, rsp_ack, rsp_err and locked are low, preg_q is all zeros, and every configuration word and signature byte reads as zero.
- R2: A cycle with cmd_valid high produces exactly one of rsp_ack or rsp_err in the following cycle; a cycle with cmd_valid low produces neither.
- R3: Operation code 0 (configuration read) while unlocked acknowledges and returns the word at cmd_addr on rsp_data.
- R4: Operation code 1 (configuration write) stores cmd_wdata at cmd_addr and acknowledges, whether locked or not.
- R5: Operation code 2 (register preload) while unlocked copies cmd_wdata[NUM_REGS-1:0] into preg_q and acknowledges.
- R6: While locked, a configuration read raises rsp_err and returns all-zero rsp_data.
- R7: While locked, a preload raises rsp_err and leaves preg_q unchanged.
- R8: Operation codes 3 (signature read) and 4 (signature write) address one byte by cmd_addr[2:0]; a read returns the byte zero-extended in rsp_data, a write stores cmd_wdata[7:0]; both acknowledge regardless of the lock.
- R9: Operation code 5 sets locked and acknowledges; the command in the very next cycle is already restricted.
- R10: Operation code 6 (full erase) clears locked and every configuration word to zero, leaves the signature untouched, and acknowledges; no other command clears locked.
- R11: Operation code 7 is rejected with rsp_err and changes no state.
- R12: rsp_data is zero on every error response and on every write, preload, lock and erase acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Configuration word address; low 3 bits select a signature byte |
| cmd_wdata | input | DATA_W | Write data for configuration, preload and signature |
| rsp_ack | output | 1 | One-cycle acknowledge |
| rsp_err | output | 1 | One-cycle refusal |
| rsp_data | output | DATA_W | Read data with the response |
| locked | output | 1 | Protection state |
| preg_q | output | NUM_REGS | Logic registers loaded by preload |

## Verification
A wrong protection state shows at the locked port on the edge after the offending command and, on the next guarded command, as an acknowledge where an error was due or the reverse. A corrupted array word or signature byte stays invisible until that location is read, so the bench reads back every word it wrote and compares against a model across random command mixes interleaved with lock and erase. A preload that slips past the lock is caught in the same response cycle through preg_q.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [2:0] {
        OP_CFG_RD  = 3'd0,
        OP_CFG_WR  = 3'd1,
        OP_PRELOAD = 3'd2,
        OP_SIG_RD  = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_LOCK    = 3'd5,
        OP_ERASE   = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef struct packed {
        logic grant;
        logic deny;
        logic cfg_rd;
        logic cfg_wr;
        logic pre_ld;
        logic sig_rd;
        logic sig_wr;
        logic lock_set;
        logic erase;
    } action_t;

    localparam int SIG_BYTES = 8;
    localparam int SIG_AW    = $clog2(SIG_BYTES);

    // Operations that the protection bit refuses.
    function automatic logic op_guarded(op_e op);
        return (op == OP_CFG_RD) || (op == OP_PRELOAD);
    endfunction

endpackage

// File: rtl/sac_decode.sv
module sac_decode
    import sac_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    input  logic       locked,
    output action_t    act
);
    op_e op_t;

    always_comb begin
        op_t = op_e'(op);
        act  = '0;
        if (valid) begin
            if (op_t == OP_RSVD || (locked && op_guarded(op_t))) begin
                act.deny = 1'b1;
            end else begin
                act.grant = 1'b1;
                case (op_t)
                    OP_CFG_RD:  act.cfg_rd   = 1'b1;
                    OP_CFG_WR:  act.cfg_wr   = 1'b1;
                    OP_PRELOAD: act.pre_ld   = 1'b1;
                    OP_SIG_RD:  act.sig_rd   = 1'b1;
                    OP_SIG_WR:  act.sig_wr   = 1'b1;
                    OP_LOCK:    act.lock_set = 1'b1;
                    OP_ERASE:   act.erase    = 1'b1;
                    default:    act.deny     = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/sac_cfg_array.sv
module sac_cfg_array #(
    parameter int WORDS = 16,
    parameter int DW    = 16,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [WORDS];
    logic          in_range;

    assign in_range = (int'(addr) < WORDS);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int w = 0; w < WORDS; w++) cells[w] <= '0;
        end else if (wr_en && in_range) begin
            cells[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) rdata = cells[addr];
    end
endmodule

// File: rtl/sac_sig_bank.sv
module sac_sig_bank
    import sac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SIG_AW-1:0] sel,
    input  logic [7:0]        wbyte,
    output logic [7:0]        rbyte
);
    logic [7:0] bytes_q [SIG_BYTES];

    for (genvar b = 0; b < SIG_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[b] <= '0;
            end else if (wr_en && (int'(sel) == b)) begin
                bytes_q[b] <= wbyte;
            end
        end
    end

    assign rbyte = bytes_q[sel];
endmodule

// File: rtl/sec_access_ctrl.sv
module sec_access_ctrl
    import sac_pkg::*;
#(
    parameter int CFG_WORDS = 16,
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 10,
    parameter int ADDR_W    = $clog2(CFG_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   cmd_wdata,
    output logic                rsp_ack,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                locked,
    output logic [NUM_REGS-1:0] preg_q
);
    action_t     act;
    logic [DATA_W-1:0] cfg_word;
    logic [7:0]        sig_byte;

    sac_decode u_decode (
        .valid  (cmd_valid),
        .op     (cmd_op),
        .locked (locked),
        .act    (act)
    );

    sac_cfg_array #(
        .WORDS (CFG_WORDS),
        .DW    (DATA_W),
        .AW    (ADDR_W)
    ) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (act.cfg_wr),
        .clear (act.erase),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .rdata (cfg_word)
    );

    sac_sig_bank u_sig (
        .clk   (clk),
        .rst   (rst),
        .wr_en (act.sig_wr),
        .sel   (cmd_addr[SIG_AW-1:0]),
        .wbyte (cmd_wdata[7:0]),
        .rbyte (sig_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ack  <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_data <= '0;
            locked   <= 1'b0;
            preg_q   <= '0;
        end else begin
            rsp_ack <= act.grant;
            rsp_err <= act.deny;
            if (act.cfg_rd)      rsp_data <= cfg_word;
            else if (act.sig_rd) rsp_data <= DATA_W'(sig_byte);
            else                 rsp_data <= '0;
            if (act.lock_set)    locked <= 1'b1;
            else if (act.erase)  locked <= 1'b0;
            if (act.pre_ld)      preg_q <= cmd_wdata[NUM_REGS-1:0];
        end
    end
endmodule

// File: rtl/sec_access_ctrl_chk.sv
module sec_access_ctrl_chk
    import sac_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [2:0]          cmd_op,
    input logic                rsp_ack,
    input logic                rsp_err,
    input logic [DATA_W-1:0]   rsp_data,
    input logic                locked,
    input logic [NUM_REGS-1:0] preg_q
);
    // R2
    resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (rsp_ack ^ rsp_err));
    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!rsp_ack && !rsp_err));
    // R6
    locked_read_denied_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_CFG_RD && locked) |=> (rsp_err && rsp_data == '0));
    // R7
    locked_preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PRELOAD && locked) |=> (rsp_err && $stable(preg_q)));
    // R8
    sig_always_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_SIG_RD || cmd_op == OP_SIG_WR)) |=> rsp_ack);
    // R9
    lock_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_LOCK) |=> locked);
    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !(cmd_valid && cmd_op == OP_ERASE)) |=> locked);
    // R11
    rsvd_denied_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_RSVD) |=> (rsp_err && $stable(preg_q)));
    // R12
    err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_data == '0);
endmodule

bind sec_access_ctrl sec_access_ctrl_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .locked    (locked),
    .preg_q    (preg_q)
);

// File: tb/sec_access_ctrl_bench.sv
module sec_access_ctrl_bench;
    localparam int CFG_WORDS = 16;
    localparam int DATA_W    = 16;
    localparam int NUM_REGS  = 10;
    localparam int ADDR_W    = 4;

    logic                clk = 1'b0;
    logic                rst;
    logic                cmd_valid;
    logic [2:0]          cmd_op;
    logic [ADDR_W-1:0]   cmd_addr;
    logic [DATA_W-1:0]   cmd_wdata;
    logic                rsp_ack;
    logic                rsp_err;
    logic [DATA_W-1:0]   rsp_data;
    logic                locked;
    logic [NUM_REGS-1:0] preg_q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model
    logic [DATA_W-1:0]   m_cfg [CFG_WORDS];
    logic [7:0]          m_sig [8];
    logic                m_lock;
    logic [NUM_REGS-1:0] m_preg;

    always #4 clk = ~clk;

    sec_access_ctrl u_sec_access_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .rsp_ack   (rsp_ack),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data),
        .locked    (locked),
        .preg_q    (preg_q)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(logic [2:0] op, logic lk);
        case (op)
            3'd0: return lk ? "R6" : "R3";
            3'd1: return "R4";
            3'd2: return lk ? "R7" : "R5";
            3'd3, 3'd4: return "R8";
            3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Issue one command, check its response one cycle later.
    task automatic issue(logic [2:0] op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd);
        logic              e_ack, e_err;
        logic [DATA_W-1:0] e_data;
        string             tag;
        tag    = op_tag(op, m_lock);
        e_ack  = 1'b1;
        e_err  = 1'b0;
        e_data = '0;
        case (op)
            3'd0: if (m_lock) begin e_ack = 0; e_err = 1; end
                  else e_data = m_cfg[a];
            3'd1: m_cfg[a] = wd;
            3'd2: if (m_lock) begin e_ack = 0; e_err = 1; end
                  else m_preg = wd[NUM_REGS-1:0];
            3'd3: e_data = DATA_W'(m_sig[a[2:0]]);
            3'd4: m_sig[a[2:0]] = wd[7:0];
            3'd5: m_lock = 1'b1;
            3'd6: begin
                m_lock = 1'b0;
                for (int w = 0; w < CFG_WORDS; w++) m_cfg[w] = '0;
            end
            default: begin e_ack = 0; e_err = 1; end
        endcase
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({tag, " ack R2"}, 32'(rsp_ack), 32'(e_ack));
        chk({tag, " err R2"}, 32'(rsp_err), 32'(e_err));
        chk({tag, " data R12"}, 32'(rsp_data), 32'(e_data));
        chk({tag, " locked"}, 32'(locked), 32'(m_lock));
        chk({tag, " preg"}, 32'(preg_q), 32'(m_preg));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_op    = '0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        for (int w = 0; w < CFG_WORDS; w++) m_cfg[w] = '0;
        for (int b = 0; b < 8; b++) m_sig[b] = '0;
        m_lock = 1'b0;
        m_preg = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 ack", 32'(rsp_ack), 0);
        chk("R1 err", 32'(rsp_err), 0);
        chk("R1 locked", 32'(locked), 0);
        chk("R1 preg", 32'(preg_q), 0);
        issue(3'd0, 4'd5, '0);
        issue(3'd3, 4'd3, '0);

        // R2 idle cycle gives no response
        @(negedge clk);
        chk("R2 idle ack", 32'(rsp_ack), 0);
        chk("R2 idle err", 32'(rsp_err), 0);

        // R3 R4 R5 R8 directed while open
        issue(3'd1, 4'd15, 16'hBEEF);
        issue(3'd0, 4'd15, '0);
        issue(3'd2, 4'd0, 16'hF3A5);
        issue(3'd4, 4'd7, 16'h12C4);
        issue(3'd3, 4'hF, '0);   // R8 upper address bits ignored

        // R9 lock then guarded commands immediately
        issue(3'd5, 4'd0, '0);
        issue(3'd0, 4'd15, '0);  // R6
        issue(3'd2, 4'd0, 16'h0155); // R7
        issue(3'd3, 4'd7, '0);   // R8 still open
        issue(3'd4, 4'd1, 16'h00AA);
        issue(3'd1, 4'd2, 16'h5555); // R4 write while locked
        issue(3'd7, 4'd0, 16'hFFFF); // R11
        issue(3'd5, 4'd0, '0);   // R9 relock harmless

        // R10 erase clears lock and array, keeps signature
        issue(3'd6, 4'd0, '0);
        issue(3'd0, 4'd2, '0);
        issue(3'd0, 4'd15, '0);
        issue(3'd3, 4'd1, '0);
        issue(3'd2, 4'd0, 16'h03FF);
        issue(3'd7, 4'd3, 16'h1234); // R11 while open

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op;
            op = 3'($urandom % 8);
            if (op == 3'd6 && ($urandom % 3) != 0) op = 3'd0;
            issue(op, ADDR_W'($urandom), DATA_W'($urandom));
            if (($urandom % 10) == 0) begin
                @(negedge clk);
                chk("R2 gap ack", 32'(rsp_ack), 0);
                chk("R2 gap err", 32'(rsp_err), 0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule